// File: doc/BRIEF.md
# Receive Mailbox Match Controller

This block holds a small bank of receive mailboxes for a flexible-data-rate CAN style controller. The host loads an identifier and a mask into each mailbox. Each mailbox then sits in one of two states, Active or Full. When the protocol engine signals that the identifier of an incoming frame is complete, a sequencer visits the mailboxes one per clock in ascending index order. It compares the identifier under each mailbox's mask. The first Active mailbox that matches receives the identifier, the payload words and, at the end, a timestamp.

A mailbox is promoted to Full only when the protocol engine later delivers its receive-OK pulse, which comes at the sixth end-of-frame bit. If an error pulse ends the frame first, the mailbox stays Active and keeps whatever payload had already been written into it. If the scan is still running when receive-OK arrives, a match-not-finished flag is raised and no mailbox is filled. A frame that matches only mailboxes that are already Full raises an overflow flag.

The host clears Full bits and interrupt status bits by writing ones to them. It can read any stored field through a combinational read port. Identifier and mask storage is not touched by reset.

Top module: `rx_mbox_match`

## Requirements
- R1: A mailbox matches an incoming identifier when the stored identifier and the incoming identifier agree on every bit where the stored mask is 1. A mask of 0xFFFF_FF00 on identifier 0x1234_5678 accepts 0x1234_56AB.
- R2: The scan starts on `id_valid`. It visits indices 0 up to NUM_BUF-1, one per clock, and the lowest-index Active match is selected.
- R3: A mailbox turns Full, shown as `full_o[i]=1`, only on the clock edge where `rx_ok` is high for its matched frame. On that same edge `ts_i` is stored as the mailbox timestamp.
- R4: An `rx_err` pulse ends the frame. The matched mailbox stays Active, and the payload words written so far remain readable.
- R5: If `rx_ok` arrives while the scan is still running, `isr_o[1]` (match not finished) is set and no `full_o` bit changes.
- R6: When any mailbox turns Full, `isr_o[0]` is set. `irq_o` is high exactly when `isr_o[0]`, `en_rbf` and `en_glb` are all 1.
- R7: The received identifier is written into the identifier field of the matched mailbox.
- R8: Full mailboxes are still compared. A frame whose identifier matches only Full mailboxes sets `isr_o[2]` (overflow) and fills nothing.
- R9: Reset clears `full_o` and `isr_o` to zero. Stored identifiers and masks keep their values through reset.
- R10: Writing 1 to a bit of `full_clr` returns that mailbox to Active. Writing 1 to a bit of `isr_clr` clears that status bit.
- R11: The read port returns the selected field of mailbox `rd_buf` combinationally. `rd_fld` codes are 0 for the identifier, 1 for the mask, 2 for the timestamp and 3 for payload word `rd_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host write strobe for identifier or mask |
| cfg_mask_sel | input | 1 | 0 writes the identifier, 1 writes the mask |
| cfg_buf | input | BUF_W | Mailbox index for the host write |
| cfg_wdata | input | ID_W | Host write data |
| rd_buf | input | BUF_W | Mailbox index for the read port |
| rd_fld | input | 2 | Field code for the read port |
| rd_word | input | WORD_IW | Payload word index for the read port |
| rd_data | output | 32 | Read data, zero-extended |
| id_valid | input | 1 | Pulse: identifier complete, start the scan |
| rx_id | input | ID_W | Received identifier |
| dat_we | input | 1 | Payload word strobe |
| dat_idx | input | WORD_IW | Payload word index |
| dat_word | input | 32 | Payload word |
| rx_ok | input | 1 | Pulse: frame good at the sixth end-of-frame bit |
| rx_err | input | 1 | Pulse: frame aborted by an error |
| ts_i | input | TS_W | Timestamp captured on rx_ok |
| full_o | output | NUM_BUF | Per-mailbox Full status |
| full_clr | input | NUM_BUF | Write-one-to-clear for Full status |
| isr_o | output | 3 | Status bits: 0 buffer full, 1 match not finished, 2 overflow |
| isr_clr | input | 3 | Write-one-to-clear for the status bits |
| en_rbf | input | 1 | Buffer-full interrupt enable |
| en_glb | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt output |

## Verification
A wrong scan index or an off-by-one in the comparison shows up as the wrong bit of `full_o` after the frame, or as a spurious overflow flag. Both become visible on the edge that carries `rx_ok`. A sequencer left in the wrong state shows up in other ways. A stale match would turn a mailbox Full after an error, and a scan that never ends would raise match-not-finished where a fill was due. A corrupted write target appears in the read port as soon as the word is written.

// File: rtl/rxm_pkg.sv
// Shared types for the receive mailbox match controller.
// Assumes: the field codes below are the read port encoding seen by the host.
package rxm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_MATCH = 2'd2
    } scan_st_e;

    typedef enum logic [1:0] {
        FLD_ID   = 2'd0,
        FLD_MASK = 2'd1,
        FLD_TS   = 2'd2,
        FLD_DATA = 2'd3
    } fld_e;

    localparam int ISR_RBF = 0;
    localparam int ISR_MNF = 1;
    localparam int ISR_OVF = 2;
    localparam int ISR_W   = 3;
endpackage

// File: rtl/rxm_store.sv
// Mailbox storage: identifier, mask, timestamp and payload words per mailbox.
// Assumes: ID_W and TS_W are at most 32; none of this storage is reset.
// A scanner identifier write wins over a host write to the same mailbox.
module rxm_store #(
    parameter int NUM_BUF = 8,
    parameter int ID_W    = 32,
    parameter int WORDS   = 16,
    parameter int TS_W    = 16,
    localparam int BUF_W   = $clog2(NUM_BUF),
    localparam int WORD_IW = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               cfg_we,
    input  logic               cfg_mask_sel,
    input  logic [BUF_W-1:0]   cfg_buf,
    input  logic [ID_W-1:0]    cfg_wdata,
    input  logic               id_we,
    input  logic [BUF_W-1:0]   id_buf,
    input  logic [ID_W-1:0]    id_wdata,
    input  logic               dat_we,
    input  logic [BUF_W-1:0]   dat_buf,
    input  logic [WORD_IW-1:0] dat_idx,
    input  logic [31:0]        dat_word,
    input  logic               ts_we,
    input  logic [BUF_W-1:0]   ts_buf,
    input  logic [TS_W-1:0]    ts_wdata,
    input  logic [BUF_W-1:0]   cmp_buf,
    output logic [ID_W-1:0]    cmp_id,
    output logic [ID_W-1:0]    cmp_mask,
    input  logic [BUF_W-1:0]   rd_buf,
    input  logic [1:0]         rd_fld,
    input  logic [WORD_IW-1:0] rd_word,
    output logic [31:0]        rd_data
);
    import rxm_pkg::*;

    logic [ID_W-1:0] id_arr   [NUM_BUF];
    logic [ID_W-1:0] mask_arr [NUM_BUF];
    logic [TS_W-1:0] ts_arr   [NUM_BUF];
    logic [31:0]     dat_arr  [NUM_BUF][WORDS];

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        logic [ID_W-1:0] id_q;
        logic [ID_W-1:0] mask_q;
        logic [TS_W-1:0] ts_q;
        logic [31:0]     dat_q [WORDS];

        // Identifier: the scanner's received-ID write has priority over the host.
        always_ff @(posedge clk) begin
            if (id_we && id_buf == BUF_W'(b))
                id_q <= id_wdata;
            else if (cfg_we && !cfg_mask_sel && cfg_buf == BUF_W'(b))
                id_q <= cfg_wdata;
        end

        // Mask: written by the host only.
        always_ff @(posedge clk) begin
            if (cfg_we && cfg_mask_sel && cfg_buf == BUF_W'(b))
                mask_q <= cfg_wdata;
        end

        // Timestamp: captured when the frame is accepted.
        always_ff @(posedge clk) begin
            if (ts_we && ts_buf == BUF_W'(b))
                ts_q <= ts_wdata;
        end

        // Payload: one word per strobe into the selected slot.
        always_ff @(posedge clk) begin
            if (dat_we && dat_buf == BUF_W'(b))
                dat_q[dat_idx] <= dat_word;
        end

        assign id_arr[b]   = id_q;
        assign mask_arr[b] = mask_q;
        assign ts_arr[b]   = ts_q;
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign dat_arr[b][w] = dat_q[w];
        end
    end

    assign cmp_id   = id_arr[cmp_buf];
    assign cmp_mask = mask_arr[cmp_buf];

    // Host read mux, zero-extending narrow fields.
    always_comb begin
        rd_data = '0;
        case (fld_e'(rd_fld))
            FLD_ID:   rd_data[ID_W-1:0] = id_arr[rd_buf];
            FLD_MASK: rd_data[ID_W-1:0] = mask_arr[rd_buf];
            FLD_TS:   rd_data[TS_W-1:0] = ts_arr[rd_buf];
            default:  rd_data = dat_arr[rd_buf][rd_word];
        endcase
    end
endmodule

// File: rtl/rxm_scan.sv
// Match sequencer: visits mailboxes in ascending order, one per clock, and
// tracks the selected mailbox until the frame ends with rx_ok or rx_err.
// Assumes: id_valid restarts the scan from any state; rx_err outranks rx_ok.
module rxm_scan #(
    parameter int NUM_BUF = 8,
    parameter int ID_W    = 32,
    localparam int BUF_W = $clog2(NUM_BUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_valid_i,
    input  logic [ID_W-1:0]    rx_id_i,
    input  logic               rx_ok_i,
    input  logic               rx_err_i,
    input  logic               dat_we_i,
    input  logic [NUM_BUF-1:0] full_i,
    input  logic [ID_W-1:0]    cmp_id_i,
    input  logic [ID_W-1:0]    cmp_mask_i,
    output logic [BUF_W-1:0]   cmp_buf_o,
    output logic               id_we_o,
    output logic [ID_W-1:0]    id_wdata_o,
    output logic               dat_we_o,
    output logic [BUF_W-1:0]   sel_o,
    output logic [NUM_BUF-1:0] full_set_o,
    output logic               mnf_set_o,
    output logic               ovf_set_o
);
    import rxm_pkg::*;

    localparam logic [BUF_W-1:0] LAST = BUF_W'(NUM_BUF - 1);

    scan_st_e        state_q;
    logic [BUF_W-1:0] idx_q, sel_q;
    logic [ID_W-1:0]  rid_q;
    logic             ovf_seen_q;
    logic             hit, scan_go, take;

    assign hit     = ((rid_q ^ cmp_id_i) & cmp_mask_i) == '0;
    assign scan_go = (state_q == ST_SCAN) && !id_valid_i && !rx_ok_i && !rx_err_i;
    assign take    = scan_go && hit && !full_i[idx_q];

    // Sequencer state, scan index and selected mailbox.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            sel_q      <= '0;
            rid_q      <= '0;
            ovf_seen_q <= 1'b0;
        end else if (id_valid_i) begin
            state_q    <= ST_SCAN;
            idx_q      <= '0;
            rid_q      <= rx_id_i;
            ovf_seen_q <= 1'b0;
        end else begin
            case (state_q)
                ST_SCAN: begin
                    if (rx_ok_i || rx_err_i) begin
                        state_q <= ST_IDLE;
                    end else if (take) begin
                        sel_q   <= idx_q;
                        state_q <= ST_MATCH;
                    end else begin
                        if (hit) ovf_seen_q <= 1'b1;
                        if (idx_q == LAST) state_q <= ST_IDLE;
                        else               idx_q   <= idx_q + BUF_W'(1);
                    end
                end
                ST_MATCH: if (rx_ok_i || rx_err_i) state_q <= ST_IDLE;
                default: ;
            endcase
        end
    end

    assign cmp_buf_o  = idx_q;
    assign id_we_o    = take;
    assign id_wdata_o = rid_q;
    assign sel_o      = (state_q == ST_MATCH) ? sel_q : idx_q;
    assign dat_we_o   = (state_q == ST_MATCH) && !id_valid_i && dat_we_i;
    assign mnf_set_o  = (state_q == ST_SCAN) && !id_valid_i && rx_ok_i && !rx_err_i;
    assign ovf_set_o  = scan_go && idx_q == LAST && !take && (ovf_seen_q || hit);
    assign full_set_o = ((state_q == ST_MATCH) && !id_valid_i && rx_ok_i && !rx_err_i)
                        ? (NUM_BUF'(1) << sel_q) : '0;

    // R2
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && $past(state_q) == ST_SCAN && !$past(id_valid_i))
        |-> idx_q == $past(idx_q) + BUF_W'(1));
endmodule

// File: rtl/rxm_status.sv
// Status bits: per-mailbox Full flags and the interrupt status register,
// both write-one-to-clear, plus the gated interrupt output.
// Assumes: a set and a clear of the same bit in one cycle leaves it set.
module rxm_status #(
    parameter int NUM_BUF = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_ok_i,
    input  logic                     rx_err_i,
    input  logic [NUM_BUF-1:0]       full_set_i,
    input  logic [NUM_BUF-1:0]       full_clr_i,
    input  logic                     mnf_set_i,
    input  logic                     ovf_set_i,
    input  logic [rxm_pkg::ISR_W-1:0] isr_clr_i,
    input  logic                     en_rbf_i,
    input  logic                     en_glb_i,
    output logic [NUM_BUF-1:0]       full_o,
    output logic [rxm_pkg::ISR_W-1:0] isr_o,
    output logic                     irq_o
);
    import rxm_pkg::*;

    logic [NUM_BUF-1:0] full_q;
    logic [ISR_W-1:0]   isr_q, isr_set;

    assign isr_set = {ovf_set_i, mnf_set_i, |full_set_i};

    // Full flags: set by the sequencer, cleared by host write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= '0;
        else        full_q <= (full_q & ~full_clr_i) | full_set_i;
    end

    // Interrupt status: set by events, cleared by host write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~isr_clr_i) | isr_set;
    end

    assign full_o = full_q;
    assign isr_o  = isr_q;
    assign irq_o  = isr_q[ISR_RBF] && en_rbf_i && en_glb_i;

    // R3
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(full_q & ~$past(full_q))) |-> $past(rx_ok_i));
    // R4
    err_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_err_i) |-> (full_q & ~$past(full_q)) == '0);
    // R5
    mnf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_q[ISR_MNF]) |-> $past(rx_ok_i) && (full_q & ~$past(full_q)) == '0);
    // R6
    rbf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_q[ISR_RBF]) |-> |(full_q & ~$past(full_q)));
endmodule

// File: rtl/rx_mbox_match.sv
// Top of the receive mailbox match controller: storage, sequencer, status.
// Assumes: payload words are 32 bits; words that arrive before a match are dropped.
module rx_mbox_match #(
    parameter int NUM_BUF       = 8,
    parameter int ID_W          = 32,
    parameter int PAYLOAD_BYTES = 64,
    parameter int TS_W          = 16,
    localparam int BUF_W   = $clog2(NUM_BUF),
    localparam int WORDS   = PAYLOAD_BYTES / 4,
    localparam int WORD_IW = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_mask_sel,
    input  logic [BUF_W-1:0]   cfg_buf,
    input  logic [ID_W-1:0]    cfg_wdata,
    input  logic [BUF_W-1:0]   rd_buf,
    input  logic [1:0]         rd_fld,
    input  logic [WORD_IW-1:0] rd_word,
    output logic [31:0]        rd_data,
    input  logic               id_valid,
    input  logic [ID_W-1:0]    rx_id,
    input  logic               dat_we,
    input  logic [WORD_IW-1:0] dat_idx,
    input  logic [31:0]        dat_word,
    input  logic               rx_ok,
    input  logic               rx_err,
    input  logic [TS_W-1:0]    ts_i,
    output logic [NUM_BUF-1:0] full_o,
    input  logic [NUM_BUF-1:0] full_clr,
    output logic [2:0]         isr_o,
    input  logic [2:0]         isr_clr,
    input  logic               en_rbf,
    input  logic               en_glb,
    output logic               irq_o
);
    logic [BUF_W-1:0]   cmp_buf, sel;
    logic [ID_W-1:0]    cmp_id, cmp_mask, id_wdata;
    logic               id_we, dat_we_int, mnf_set, ovf_set;
    logic [NUM_BUF-1:0] full_set;

    rxm_store #(.NUM_BUF(NUM_BUF), .ID_W(ID_W), .WORDS(WORDS), .TS_W(TS_W)) u_store (
        .clk(clk), .cfg_we(cfg_we), .cfg_mask_sel(cfg_mask_sel), .cfg_buf(cfg_buf),
        .cfg_wdata(cfg_wdata), .id_we(id_we), .id_buf(cmp_buf), .id_wdata(id_wdata),
        .dat_we(dat_we_int), .dat_buf(sel), .dat_idx(dat_idx), .dat_word(dat_word),
        .ts_we(|full_set), .ts_buf(sel), .ts_wdata(ts_i), .cmp_buf(cmp_buf),
        .cmp_id(cmp_id), .cmp_mask(cmp_mask), .rd_buf(rd_buf), .rd_fld(rd_fld),
        .rd_word(rd_word), .rd_data(rd_data));

    rxm_scan #(.NUM_BUF(NUM_BUF), .ID_W(ID_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid), .rx_id_i(rx_id),
        .rx_ok_i(rx_ok), .rx_err_i(rx_err), .dat_we_i(dat_we), .full_i(full_o),
        .cmp_id_i(cmp_id), .cmp_mask_i(cmp_mask), .cmp_buf_o(cmp_buf),
        .id_we_o(id_we), .id_wdata_o(id_wdata), .dat_we_o(dat_we_int), .sel_o(sel),
        .full_set_o(full_set), .mnf_set_o(mnf_set), .ovf_set_o(ovf_set));

    rxm_status #(.NUM_BUF(NUM_BUF)) u_status (
        .clk(clk), .rst_n(rst_n), .rx_ok_i(rx_ok), .rx_err_i(rx_err),
        .full_set_i(full_set), .full_clr_i(full_clr), .mnf_set_i(mnf_set),
        .ovf_set_i(ovf_set), .isr_clr_i(isr_clr), .en_rbf_i(en_rbf),
        .en_glb_i(en_glb), .full_o(full_o), .isr_o(isr_o), .irq_o(irq_o));
endmodule

// File: tb/rx_mbox_match_tb.sv
// Bench: a vector table of frames with expected Full masks and overflow,
// followed by directed tests for reset, late scan, clear and interrupt gating.
module rx_mbox_match_tb;
    localparam int NB = 8;
    localparam int WORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_mask_sel = 0;
    logic [2:0]  cfg_buf = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  rd_buf = '0;
    logic [1:0]  rd_fld = '0;
    logic [3:0]  rd_word = '0;
    logic [31:0] rd_data;
    logic        id_valid = 0;
    logic [31:0] rx_id = '0;
    logic        dat_we = 0;
    logic [3:0]  dat_idx = '0;
    logic [31:0] dat_word = '0;
    logic        rx_ok = 0, rx_err = 0;
    logic [15:0] ts_i = '0;
    logic [7:0]  full_o, full_clr = '0;
    logic [2:0]  isr_o, isr_clr = '0;
    logic        en_rbf = 1, en_glb = 1, irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rx_mbox_match u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask_sel(cfg_mask_sel),
        .cfg_buf(cfg_buf), .cfg_wdata(cfg_wdata), .rd_buf(rd_buf), .rd_fld(rd_fld),
        .rd_word(rd_word), .rd_data(rd_data), .id_valid(id_valid), .rx_id(rx_id),
        .dat_we(dat_we), .dat_idx(dat_idx), .dat_word(dat_word), .rx_ok(rx_ok),
        .rx_err(rx_err), .ts_i(ts_i), .full_o(full_o), .full_clr(full_clr),
        .isr_o(isr_o), .isr_clr(isr_clr), .en_rbf(en_rbf), .en_glb(en_glb),
        .irq_o(irq_o));

    // Stimulus {identifier, error, expected full mask, expected overflow}.
    localparam logic [41:0] VEC [7] = '{
        {32'h1234_56AB, 1'b0, 8'h01, 1'b0},
        {32'h0000_0ABC, 1'b0, 8'h03, 1'b0},
        {32'h0000_0ABC, 1'b0, 8'h07, 1'b0},
        {32'h0000_0ABC, 1'b0, 8'h07, 1'b1},
        {32'hDEAD_0005, 1'b1, 8'h07, 1'b0},
        {32'hDEAD_0005, 1'b0, 8'h27, 1'b0},
        {32'h5555_5555, 1'b0, 8'h27, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic cfg(input logic [2:0] b, input logic msel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_mask_sel = msel; cfg_buf = b; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(input logic [2:0] b, input logic [1:0] f, input logic [3:0] w,
                      output logic [31:0] v);
        rd_buf = b; rd_fld = f; rd_word = w;
        #1 v = rd_data;
    endtask

    task automatic frame(input logic [31:0] id, input logic err, input logic late,
                         input logic [15:0] ts);
        @(negedge clk);
        id_valid = 1; rx_id = id;
        @(negedge clk);
        id_valid = 0;
        if (!late) begin
            repeat (10) @(negedge clk);
            for (int k = 0; k < WORDS; k++) begin
                dat_we = 1; dat_idx = 4'(k); dat_word = id ^ 32'(k);
                @(negedge clk);
            end
            dat_we = 0;
        end
        rx_ok = !err; rx_err = err; ts_i = ts;
        @(negedge clk);
        rx_ok = 0; rx_err = 0;
        @(negedge clk);
    endtask

    task automatic clr_isr;
        isr_clr = 3'b111;
        @(negedge clk);
        isr_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  prev;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check("R9 full after reset", 32'(full_o), 32'h0);
        check("R9 isr after reset", 32'(isr_o), 32'h0);
        check("R6 irq after reset", 32'(irq_o), 32'h0);

        cfg(3'd0, 0, 32'h1234_5678); cfg(3'd0, 1, 32'hFFFF_FF00);
        cfg(3'd1, 0, 32'h0000_0ABC); cfg(3'd1, 1, 32'hFFFF_FFFF);
        cfg(3'd2, 0, 32'h0000_0AB0); cfg(3'd2, 1, 32'hFFFF_FFF0);
        for (int b = 3; b < NB; b++) begin
            cfg(3'(b), 0, 32'hDEAD_0000 + 32'(b));
            cfg(3'(b), 1, 32'hFFFF_FFFF);
        end
        rd(3'd2, 2'd1, 4'd0, v);
        check("R11 mask readback", v, 32'hFFFF_FFF0);

        // Vector table: R1 masked match, R2 lowest index, R8 overflow, R4 error
        for (int i = 0; i < 7; i++) begin
            prev = full_o;
            frame(VEC[i][41:10], VEC[i][9], 1'b0, 16'hA000 + 16'(i));
            check("R1/R2 full mask", 32'(full_o), 32'(VEC[i][8:1]));
            check("R8 overflow flag", 32'(isr_o[2]), 32'(VEC[i][0]));
            check("R6 rbf flag", 32'(isr_o[0]), 32'(full_o != prev));
            if (VEC[i][9]) begin
                rd(VEC[i][44-3 -: 1] ? 3'd5 : 3'd5, 2'd3, 4'd7, v);
                check("R4 partial payload kept", v, VEC[i][41:10] ^ 32'd7);
            end
            clr_isr();
        end
        check("R10 isr cleared", 32'(isr_o), 32'h0);
        rd(3'd0, 2'd0, 4'd0, v);
        check("R7 received id stored", v, 32'h1234_56AB);
        rd(3'd5, 2'd2, 4'd0, v);
        check("R3 timestamp", v, 32'h0000_A005);
        rd(3'd5, 2'd3, 4'd12, v);
        check("R11 payload word", v, 32'hDEAD_0005 ^ 32'd12);

        // R10 full clear, then refill through R1
        full_clr = 8'h01;
        @(negedge clk);
        full_clr = '0;
        check("R10 full clear", 32'(full_o), 32'h26);
        frame(32'h1234_5600, 1'b0, 1'b0, 16'h0001);
        check("R1 refill buf0", 32'(full_o), 32'h27);
        check("R6 irq enabled", 32'(irq_o), 32'h1);
        en_glb = 0; #1;
        check("R6 irq global off", 32'(irq_o), 32'h0);
        en_glb = 1; en_rbf = 0; #1;
        check("R6 irq rbf off", 32'(irq_o), 32'h0);
        en_rbf = 1;

        // R9 ID/Mask survive reset
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R9 full reset", 32'(full_o), 32'h0);
        check("R9 isr reset", 32'(isr_o), 32'h0);
        rd(3'd3, 2'd0, 4'd0, v);
        check("R9 id kept", v, 32'hDEAD_0003);
        rd(3'd3, 2'd1, 4'd0, v);
        check("R9 mask kept", v, 32'hFFFF_FFFF);

        // R5 late scan: rx_ok two edges after id_valid, buffer 6 not yet visited
        frame(32'hDEAD_0006, 1'b0, 1'b1, 16'h0002);
        check("R5 mnf flag", 32'(isr_o[1]), 32'h1);
        check("R5 no fill", 32'(full_o), 32'h0);
        check("R5 no rbf", 32'(isr_o[0]), 32'h0);

        summary();
        $finish;
    end
endmodule